// File: doc/BRIEF.md
# Ring Stop with Bounce Forwarding

This block is the attachment point of one node on a unidirectional ring. The ring is a chain of registered slots; each stop holds one slot register, so a flit moves exactly one stop per clock. A slot carries a valid bit, a destination node number and a payload. Every cycle the stop looks at the flit arriving from the upstream stop and does one of four things with the outgoing slot. It forwards a flit meant for another node. It takes a flit meant for itself into a four-entry ejection FIFO. It sends a flit meant for itself onward again when that FIFO is full. It loads a local flit into a slot that is empty or has just been vacated by ejection.

Flits already on the ring always win over local traffic, and a full ejection FIFO never stalls the ring: the flit goes round once more and retries on a later pass. Flits from one source to one destination can therefore arrive out of order, and the stop does not restore order.

The decision is named by an action code: ACT_IDLE (nothing arrives, nothing to inject), ACT_PASS (foreign flit forwarded), ACT_BOUNCE (own flit, FIFO full, forwarded), ACT_EJECT (own flit taken, slot left empty), ACT_EJECT_INJECT (own flit taken, local flit loaded), ACT_INJECT (empty slot, local flit loaded). The registered slot state is SLOT_EMPTY, SLOT_RING (holding a forwarded or bounced flit) or SLOT_LOCAL (holding an injected flit). Transitions: ACT_IDLE and ACT_EJECT lead to SLOT_EMPTY; ACT_PASS and ACT_BOUNCE lead to SLOT_RING; ACT_INJECT and ACT_EJECT_INJECT lead to SLOT_LOCAL. Any state can move to any other in one cycle.

Top module: `ring_stop`

## Requirements
- R1: After reset, the outgoing slot is empty (ring_out_vld low) and the ejection port shows no flit (ej_vld low).
- R2: A valid incoming flit whose destination differs from NODE_ID appears on the outgoing slot one cycle later with destination and payload unchanged.
- R3: A valid incoming flit whose destination equals NODE_ID, arriving while the ejection FIFO holds fewer than 4 entries, is written into the FIFO and does not appear on the outgoing slot.
- R4: A valid incoming flit whose destination equals NODE_ID, arriving while the ejection FIFO holds 4 entries, appears on the outgoing slot one cycle later unchanged (bounce); fullness is judged on the current occupancy, not on a pop in the same cycle.
- R5: inj_rdy is high exactly when no incoming flit is present, or when the incoming flit is being ejected in that cycle.
- R6: When inj_vld and inj_rdy are both high, the local flit (inj_dest, inj_data) appears on the outgoing slot one cycle later.
- R7: When an incoming flit stays on the ring while a local flit is offered, the ring flit takes the outgoing slot and the local flit is not accepted.
- R8: The ejection port presents entries in the order they were written; ej_data is held steady while ej_vld is high and ej_rdy is low.
- R9: When no incoming flit is present and no local flit is offered, the outgoing slot is empty one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_vld | input | 1 | Incoming slot holds a flit |
| ring_in_dest | input | ID_W | Destination node of incoming flit |
| ring_in_data | input | DATA_W | Payload of incoming flit |
| ring_out_vld | output | 1 | Outgoing slot holds a flit |
| ring_out_dest | output | ID_W | Destination node of outgoing flit |
| ring_out_data | output | DATA_W | Payload of outgoing flit |
| inj_vld | input | 1 | Local flit offered |
| inj_rdy | output | 1 | Local flit accepted this cycle |
| inj_dest | input | ID_W | Destination node of local flit |
| inj_data | input | DATA_W | Payload of local flit |
| ej_vld | output | 1 | Ejection FIFO not empty |
| ej_rdy | input | 1 | Local sink takes the head entry |
| ej_data | output | DATA_W | Payload at the head of the ejection FIFO |

## Verification
The bench builds the stop with NODE_ID 2, a two-bit destination field and eight-bit payloads, so all four destinations, including the stop's own, can be swept. For each FIFO occupancy from 0 to 4 it tries every combination of incoming-valid, destination and local-offer, which reaches the exact boundary where a fifth own flit bounces instead of ejecting. Each case is then drained through the ejection port to confirm the entry count and write order.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PASS,
        ACT_BOUNCE,
        ACT_EJECT,
        ACT_EJECT_INJECT,
        ACT_INJECT
    } act_e;

    typedef enum logic [1:0] {
        SLOT_EMPTY,
        SLOT_RING,
        SLOT_LOCAL
    } slot_e;

endpackage

// File: rtl/ring_stop_arb.sv
module ring_stop_arb
    import ring_stop_pkg::*;
#(
    parameter int NODE_ID = 0,
    parameter int ID_W    = 2
) (
    input  logic            rin_vld,
    input  logic [ID_W-1:0] rin_dest,
    input  logic            ej_full,
    input  logic            inj_vld,
    output logic            inj_rdy,
    output logic            ej_push,
    output act_e            act
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic hit;

    assign hit     = rin_vld && (rin_dest == MY_ID);
    assign ej_push = hit && !ej_full;
    assign inj_rdy = !rin_vld || ej_push;

    always_comb begin
        unique case ({rin_vld, hit})
            2'b00:   act = inj_vld ? ACT_INJECT : ACT_IDLE;
            2'b10:   act = ACT_PASS;
            2'b11:   act = ej_full ? ACT_BOUNCE
                         : (inj_vld ? ACT_EJECT_INJECT : ACT_EJECT);
            default: act = ACT_IDLE;
        endcase
    end

endmodule

// File: rtl/ring_stop_fifo.sv
module ring_stop_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic              not_empty,
    output logic [DATA_W-1:0] head
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign full      = (count == CNT_W'(DEPTH));
    assign not_empty = (count != '0);
    assign head      = mem[rd_ptr];
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/ring_stop.sv
module ring_stop
    import ring_stop_pkg::*;
#(
    parameter int NODE_ID  = 0,
    parameter int ID_W     = 2,
    parameter int DATA_W   = 8,
    parameter int EJ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_in_vld,
    input  logic [ID_W-1:0]   ring_in_dest,
    input  logic [DATA_W-1:0] ring_in_data,
    output logic              ring_out_vld,
    output logic [ID_W-1:0]   ring_out_dest,
    output logic [DATA_W-1:0] ring_out_data,
    input  logic              inj_vld,
    output logic              inj_rdy,
    input  logic [ID_W-1:0]   inj_dest,
    input  logic [DATA_W-1:0] inj_data,
    output logic              ej_vld,
    input  logic              ej_rdy,
    output logic [DATA_W-1:0] ej_data
);

    act_e              act;
    slot_e             slot_q, slot_d;
    logic              ej_full;
    logic              ej_push;
    logic [ID_W-1:0]   dest_q, dest_d;
    logic [DATA_W-1:0] data_q, data_d;

    ring_stop_arb #(
        .NODE_ID (NODE_ID),
        .ID_W    (ID_W)
    ) arb_i (
        .rin_vld  (ring_in_vld),
        .rin_dest (ring_in_dest),
        .ej_full  (ej_full),
        .inj_vld  (inj_vld),
        .inj_rdy  (inj_rdy),
        .ej_push  (ej_push),
        .act      (act)
    );

    ring_stop_fifo #(
        .DEPTH  (EJ_DEPTH),
        .DATA_W (DATA_W)
    ) ej_fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ej_push),
        .push_data (ring_in_data),
        .pop       (ej_rdy),
        .full      (ej_full),
        .not_empty (ej_vld),
        .head      (ej_data)
    );

    // next slot contents chosen by the arbitration action
    always_comb begin
        slot_d = SLOT_EMPTY;
        dest_d = dest_q;
        data_d = data_q;
        unique case (act)
            ACT_IDLE, ACT_EJECT: begin
                slot_d = SLOT_EMPTY;
            end
            ACT_PASS, ACT_BOUNCE: begin
                slot_d = SLOT_RING;
                dest_d = ring_in_dest;
                data_d = ring_in_data;
            end
            ACT_INJECT, ACT_EJECT_INJECT: begin
                slot_d = SLOT_LOCAL;
                dest_d = inj_dest;
                data_d = inj_data;
            end
            default: begin
                slot_d = SLOT_EMPTY;
            end
        endcase
    end

    // slot state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_ff @(posedge clk) begin
        dest_q <= dest_d;
        data_q <= data_d;
    end

    // outputs from slot state
    always_comb begin
        ring_out_vld  = (slot_q != SLOT_EMPTY);
        ring_out_dest = dest_q;
        ring_out_data = data_q;
    end

endmodule

// File: rtl/ring_stop_chk.sv
module ring_stop_chk #(
    parameter int NODE_ID = 0,
    parameter int ID_W    = 2,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_in_vld,
    input logic [ID_W-1:0]   ring_in_dest,
    input logic [DATA_W-1:0] ring_in_data,
    input logic              ring_out_vld,
    input logic [ID_W-1:0]   ring_out_dest,
    input logic [DATA_W-1:0] ring_out_data,
    input logic              inj_vld,
    input logic              inj_rdy,
    input logic [DATA_W-1:0] inj_data,
    input logic              ej_vld,
    input logic              ej_rdy,
    input logic [DATA_W-1:0] ej_data,
    input logic              ej_full
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic own;
    assign own = ring_in_vld && (ring_in_dest == MY_ID);

    AST_FORWARD_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_in_vld && ring_in_dest != MY_ID) |=>
        (ring_out_vld && ring_out_dest == $past(ring_in_dest)
         && ring_out_data == $past(ring_in_data))); // R2

    AST_EJECT_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (own && !ej_full && !inj_vld) |=> !ring_out_vld); // R3

    AST_BOUNCE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (own && ej_full) |=>
        (ring_out_vld && ring_out_dest == MY_ID
         && ring_out_data == $past(ring_in_data))); // R4

    AST_RING_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_in_vld && !(own && !ej_full)) |-> !inj_rdy); // R7

    AST_INJECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && inj_rdy) |=>
        (ring_out_vld && ring_out_data == $past(inj_data))); // R6

    AST_EJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_vld && !ej_rdy && !own) |=> (ej_vld && $stable(ej_data))); // R8

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_in_vld && !inj_vld) |=> !ring_out_vld); // R9

endmodule

bind ring_stop ring_stop_chk #(
    .NODE_ID (NODE_ID),
    .ID_W    (ID_W),
    .DATA_W  (DATA_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_in_vld   (ring_in_vld),
    .ring_in_dest  (ring_in_dest),
    .ring_in_data  (ring_in_data),
    .ring_out_vld  (ring_out_vld),
    .ring_out_dest (ring_out_dest),
    .ring_out_data (ring_out_data),
    .inj_vld       (inj_vld),
    .inj_rdy       (inj_rdy),
    .inj_data      (inj_data),
    .ej_vld        (ej_vld),
    .ej_rdy        (ej_rdy),
    .ej_data       (ej_data),
    .ej_full       (ej_full)
);

// File: tb/ring_stop_tb_top.sv
module ring_stop_tb_top;

    localparam int NODE  = 2;
    localparam int IDW   = 2;
    localparam int DW    = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ring_in_vld = 1'b0;
    logic [IDW-1:0] ring_in_dest = '0;
    logic [DW-1:0] ring_in_data = '0;
    logic          ring_out_vld;
    logic [IDW-1:0] ring_out_dest;
    logic [DW-1:0] ring_out_data;
    logic          inj_vld = 1'b0;
    logic          inj_rdy;
    logic [IDW-1:0] inj_dest = '0;
    logic [DW-1:0] inj_data = '0;
    logic          ej_vld;
    logic          ej_rdy = 1'b0;
    logic [DW-1:0] ej_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ring_stop #(
        .NODE_ID  (NODE),
        .ID_W     (IDW),
        .DATA_W   (DW),
        .EJ_DEPTH (DEPTH)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ring_in_vld   (ring_in_vld),
        .ring_in_dest  (ring_in_dest),
        .ring_in_data  (ring_in_data),
        .ring_out_vld  (ring_out_vld),
        .ring_out_dest (ring_out_dest),
        .ring_out_data (ring_out_data),
        .inj_vld       (inj_vld),
        .inj_rdy       (inj_rdy),
        .inj_dest      (inj_dest),
        .inj_data      (inj_data),
        .ej_vld        (ej_vld),
        .ej_rdy        (ej_rdy),
        .ej_data       (ej_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ring_in_vld = 1'b0;
        inj_vld     = 1'b0;
        ej_rdy      = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(ring_out_vld == 1'b0, "R1", "ring_out_vld after reset", ring_out_vld, 0);
        chk(ej_vld == 1'b0, "R1", "ej_vld after reset", ej_vld, 0);
    endtask

    initial begin
        for (int n = 0; n <= DEPTH; n++) begin
            for (int rv = 0; rv < 2; rv++) begin
                for (int d = 0; d < 4; d++) begin
                    for (int iv = 0; iv < 2; iv++) begin
                        bit hit, ejok, exp_rdy, exp_ov;
                        logic [IDW-1:0] exp_od;
                        logic [DW-1:0] exp_odata;
                        int exp_cnt;
                        string tag;

                        do_reset();
                        // fill FIFO with n own flits, sink stalled
                        for (int k = 0; k < n; k++) begin
                            ring_in_vld  = 1'b1;
                            ring_in_dest = IDW'(NODE);
                            ring_in_data = DW'(8'h10 + k);
                            @(negedge clk);
                        end
                        idle_inputs();
                        @(negedge clk);

                        // stimulus cycle
                        ring_in_vld  = rv[0];
                        ring_in_dest = IDW'(d);
                        ring_in_data = 8'hA5;
                        inj_vld      = iv[0];
                        inj_dest     = IDW'((d + 1) % 4);
                        inj_data     = 8'h5C;
                        #1;
                        hit     = (rv == 1) && (d == NODE);
                        ejok    = hit && (n < DEPTH);
                        exp_rdy = (rv == 0) || ejok;
                        chk(inj_rdy == exp_rdy, "R5", "inj_rdy", inj_rdy, exp_rdy);

                        if (rv == 1 && !ejok) begin
                            exp_ov = 1'b1; exp_od = IDW'(d); exp_odata = 8'hA5;
                        end else if (iv == 1) begin
                            exp_ov = 1'b1; exp_od = IDW'((d + 1) % 4); exp_odata = 8'h5C;
                        end else begin
                            exp_ov = 1'b0; exp_od = '0; exp_odata = '0;
                        end
                        if (rv == 0) tag = (iv == 1) ? "R6" : "R9";
                        else if (!hit) tag = (iv == 1) ? "R7" : "R2";
                        else if (ejok) tag = (iv == 1) ? "R6" : "R3";
                        else tag = (iv == 1) ? "R7" : "R4";

                        @(negedge clk);
                        idle_inputs();
                        chk(ring_out_vld == exp_ov, tag, "ring_out_vld", ring_out_vld, exp_ov);
                        if (exp_ov) begin
                            chk(ring_out_dest == exp_od, tag, "ring_out_dest", ring_out_dest, exp_od);
                            chk(ring_out_data == exp_odata, tag, "ring_out_data", ring_out_data, exp_odata);
                        end

                        // drain and check order
                        exp_cnt = n + (ejok ? 1 : 0);
                        for (int k = 0; k < exp_cnt; k++) begin
                            logic [DW-1:0] e;
                            e = (k < n) ? DW'(8'h10 + k) : 8'hA5;
                            chk(ej_vld == 1'b1, "R8", "ej_vld during drain", ej_vld, 1);
                            chk(ej_data == e, (k < n) ? "R8" : "R3", "ej_data order", ej_data, e);
                            ej_rdy = 1'b1;
                            @(negedge clk);
                            ej_rdy = 1'b0;
                        end
                        chk(ej_vld == 1'b0, (n == DEPTH && hit) ? "R4" : "R8",
                            "ej_vld after drain", ej_vld, 0);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule